// File: doc/BRIEF.md
# Readout Record Formatter with Comma Framing

The block turns readout events into a byte stream for a downstream 8b/10b encoder. Each event is one of five kinds: a trigger header, a pixel hit pair, a register address, a register value or a service message. The block packs the event into a fixed 24-bit record. An 8-bit prefix marks every record kind except the hit record. Records wait in a small queue and are sent as three data bytes each. The framer puts a start comma before a group of records and an end comma after it. Idle commas fill every byte slot in which no frame is open.

Each output byte comes with a flag that marks control characters. The 8b/10b stage uses this flag to choose between K and D codes. The output register holds its value while the downstream stage stalls.

A frame ends in one of three cases: the queue has run dry at a record boundary, the frame has reached the configured record limit, or a new trigger header is waiting. A header therefore always opens the frame that carries that trigger's hits.

Top module: `rf_formatter`

## Requirements
- R1: While `rst` is high, `out_valid` is low. After reset, with nothing queued, the block presents the idle comma K28.1 (byte 0x3C, `out_is_k` = 1).
- R2: A header event (`in_kind` = 0) becomes the record {8'hE9, 4'b0000, trigger[3:0], bunch crossing[7:0]}.
- R3: A hit event (`in_kind` = 1) becomes the record {column[6:0], row[8:0], top ToT[3:0], bottom ToT[3:0]}. Columns run from 1 to 80, so the top byte never matches a prefix.
- R4: An address event (`in_kind` = 2) becomes {8'hEA, type, address[14:0]}. A value event (`in_kind` = 3) becomes {8'hEC, value[15:0]}. A service event (`in_kind` = 4) becomes {8'hEF, code[15:0]}. A value may appear with no address before it.
- R5: Each record leaves as three bytes, bits 23:16 first and bits 7:0 last, all with `out_is_k` = 0.
- R6: A frame is K28.7 (0xFC), one or more records, then K28.5 (0xBC), all commas with `out_is_k` = 1. Idle commas appear only outside frames. Records reach the output in the order their events were accepted.
- R7: If a header is at the head of the queue while the open frame already holds records, the frame is closed, and the header becomes the first record of the next frame.
- R8: A frame never holds more than MAX_REC records. When the limit is reached, the frame closes even if more records are waiting.
- R9: If the queue is empty at a record boundary inside a frame, the frame closes at once.
- R10: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_is_k` and `out_valid` keep their values into the next cycle.
- R11: `in_ready` stays high until DEPTH events are queued and drops while the queue is full. An event offered then is not taken.
- R12: Kind codes 5, 6 and 7 are accepted and dropped. They produce no record and do not split a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Event offered |
| in_ready | output | 1 | Event queue has room |
| in_kind | input | 3 | 0 header, 1 hit, 2 address, 3 value, 4 service, 5-7 dropped |
| in_trig | input | 4 | Header trigger number |
| in_bcid | input | 8 | Header bunch-crossing number |
| in_col | input | 7 | Hit column |
| in_row | input | 9 | Hit row |
| in_tot_top | input | 4 | Hit ToT, upper pixel |
| in_tot_bot | input | 4 | Hit ToT, lower pixel |
| in_reg_type | input | 1 | Address type: 0 global register, 1 shift register |
| in_word | input | 16 | Address (bits 14:0), value or service code |
| out_byte | output | 8 | Byte to the line encoder |
| out_is_k | output | 1 | Byte is a control character |
| out_valid | output | 1 | Byte is presented |
| out_ready | input | 1 | Downstream takes the byte |

## Verification
The bench decodes the output, discards idle commas and compares the result byte for byte with a stream built from the record formulas and the frame-closing rules. One run preloads the queue while the output is stalled. The frame cut points then depend only on the headers and the record limit. A design that ignored the limit, or that let a header join a frame already holding records, would yield a different number of frames. Another run fills the queue to capacity to check where `in_ready` drops; an off-by-one queue would take one event too many or too few. Trickled events must each form a frame of one record with idle commas in between, which catches a framer that waits for more data before it closes. An alternating `out_ready` during a burst shows whether any byte changes or is lost while the output is stalled.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam logic [2:0] KIND_HDR  = 3'd0;
  localparam logic [2:0] KIND_HIT  = 3'd1;
  localparam logic [2:0] KIND_ADDR = 3'd2;
  localparam logic [2:0] KIND_VAL  = 3'd3;
  localparam logic [2:0] KIND_SVC  = 3'd4;

  localparam logic [7:0] PFX_HDR  = 8'hE9;
  localparam logic [7:0] PFX_ADDR = 8'hEA;
  localparam logic [7:0] PFX_VAL  = 8'hEC;
  localparam logic [7:0] PFX_SVC  = 8'hEF;

  // K28.7 start, K28.5 end, K28.1 idle
  localparam logic [7:0] K_SOF  = 8'hFC;
  localparam logic [7:0] K_EOF  = 8'hBC;
  localparam logic [7:0] K_IDLE = 8'h3C;

  typedef struct packed {
    logic        is_hdr;
    logic [23:0] word;
  } rec_entry_t;

  localparam int ENTRY_W = $bits(rec_entry_t);
endpackage

// File: rtl/rf_encoder.sv
module rf_encoder
  import rf_pkg::*;
(
  input  logic [2:0]  kind,
  input  logic [3:0]  trig,
  input  logic [7:0]  bcid,
  input  logic [6:0]  col,
  input  logic [8:0]  row,
  input  logic [3:0]  tot_top,
  input  logic [3:0]  tot_bot,
  input  logic        reg_type,
  input  logic [15:0] word_in,
  output rec_entry_t  entry,
  output logic        keep
);
  always_comb begin
    entry.is_hdr = 1'b0;
    entry.word   = 24'h0;
    keep         = 1'b1;
    case (kind)
      KIND_HDR: begin
        entry.is_hdr = 1'b1;
        entry.word   = {PFX_HDR, 4'b0000, trig, bcid};
      end
      KIND_HIT:  entry.word = {col, row, tot_top, tot_bot};
      KIND_ADDR: entry.word = {PFX_ADDR, reg_type, word_in[14:0]};
      KIND_VAL:  entry.word = {PFX_VAL, word_in};
      KIND_SVC:  entry.word = {PFX_SVC, word_in};
      default:   keep = 1'b0;
    endcase
  end
endmodule

// File: rtl/rf_fifo.sv
module rf_fifo #(
  parameter int WIDTH = 25,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rf_framer.sv
module rf_framer
  import rf_pkg::*;
#(
  parameter int MAX_REC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  rec_entry_t head,
  input  logic       q_empty,
  output logic       pop,
  output logic [7:0] out_byte,
  output logic       out_is_k,
  output logic       out_valid,
  input  logic       out_ready
);
  localparam int CNT_W = $clog2(MAX_REC + 1);

  typedef enum logic {ST_GAP, ST_FRAME} fr_state_t;

  fr_state_t   state_q, state_d;
  logic [1:0]  idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]  byte_d;
  logic        k_d;
  logic        advance;
  logic        take;
  logic        must_close;

  assign advance = !out_valid || out_ready;

  assign must_close = q_empty
                   || (cnt_q == CNT_W'(MAX_REC))
                   || (head.is_hdr && (cnt_q != '0));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    byte_d  = K_IDLE;
    k_d     = 1'b1;
    take    = 1'b0;
    case (state_q)
      ST_GAP: begin
        if (!q_empty) begin
          byte_d  = K_SOF;
          state_d = ST_FRAME;
          idx_d   = 2'd0;
          cnt_d   = '0;
        end
      end
      default: begin
        if (idx_q == 2'd0 && must_close) begin
          byte_d  = K_EOF;
          state_d = ST_GAP;
        end else begin
          k_d = 1'b0;
          case (idx_q)
            2'd0:    byte_d = head.word[23:16];
            2'd1:    byte_d = head.word[15:8];
            default: byte_d = head.word[7:0];
          endcase
          if (idx_q == 2'd2) begin
            idx_d = 2'd0;
            take  = 1'b1;
            cnt_d = cnt_q + 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
    endcase
  end

  assign pop = advance && take;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_GAP;
      idx_q     <= 2'd0;
      cnt_q     <= '0;
      out_byte  <= K_IDLE;
      out_is_k  <= 1'b1;
      out_valid <= 1'b0;
    end else if (advance) begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      out_byte  <= byte_d;
      out_is_k  <= k_d;
      out_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/rf_formatter.sv
module rf_formatter
  import rf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int MAX_REC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_kind,
  input  logic [3:0]  in_trig,
  input  logic [7:0]  in_bcid,
  input  logic [6:0]  in_col,
  input  logic [8:0]  in_row,
  input  logic [3:0]  in_tot_top,
  input  logic [3:0]  in_tot_bot,
  input  logic        in_reg_type,
  input  logic [15:0] in_word,
  output logic [7:0]  out_byte,
  output logic        out_is_k,
  output logic        out_valid,
  input  logic        out_ready
);
  rec_entry_t enc_entry, head;
  logic       enc_keep;
  logic       q_empty, q_full, q_pop, q_push;
  logic [ENTRY_W-1:0] head_bits;

  rf_encoder u_enc (
    .kind(in_kind), .trig(in_trig), .bcid(in_bcid), .col(in_col),
    .row(in_row), .tot_top(in_tot_top), .tot_bot(in_tot_bot),
    .reg_type(in_reg_type), .word_in(in_word),
    .entry(enc_entry), .keep(enc_keep)
  );

  assign in_ready = !q_full;
  assign q_push   = in_valid && in_ready && enc_keep;

  rf_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .wr_en(q_push), .wr_data(enc_entry),
    .rd_en(q_pop), .rd_data(head_bits), .empty(q_empty), .full(q_full)
  );

  assign head = rec_entry_t'(head_bits);

  rf_framer #(.MAX_REC(MAX_REC)) u_fr (
    .clk(clk), .rst(rst), .head(head), .q_empty(q_empty), .pop(q_pop),
    .out_byte(out_byte), .out_is_k(out_is_k), .out_valid(out_valid),
    .out_ready(out_ready)
  );
endmodule

// File: rtl/rf_formatter_chk.sv
module rf_formatter_chk #(
  parameter int MAX_REC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] out_byte,
  input logic       out_is_k,
  input logic       out_valid,
  input logic       out_ready
);
  localparam int DC_W = $clog2(3 * MAX_REC + 2);

  logic            acc;
  logic            in_frame;
  logic [DC_W-1:0] data_cnt;

  assign acc = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      data_cnt <= '0;
    end else if (acc) begin
      if (out_is_k && out_byte == 8'hFC) begin
        in_frame <= 1'b1;
        data_cnt <= '0;
      end else if (out_is_k && out_byte == 8'hBC) begin
        in_frame <= 1'b0;
      end else if (!out_is_k) begin
        data_cnt <= data_cnt + 1'b1;
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_k)));

  // R6
  kchar_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_k) |-> (out_byte == 8'hFC || out_byte == 8'hBC || out_byte == 8'h3C));

  // R6
  sof_then_data_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && out_is_k && out_byte == 8'hFC) |=> !out_is_k);

  // R6
  idle_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && out_is_k && out_byte == 8'h3C) |-> !in_frame);

  // R5
  data_inside_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !out_is_k) |-> in_frame);

  // R8
  rec_limit_chk: assert property (@(posedge clk) disable iff (rst)
    data_cnt <= DC_W'(3 * MAX_REC));

  // R5
  eof_whole_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && out_is_k && out_byte == 8'hBC) |-> (in_frame && data_cnt != '0 && (data_cnt % 3) == 0));
endmodule

bind rf_formatter rf_formatter_chk #(.MAX_REC(MAX_REC)) u_chk (
  .clk(clk), .rst(rst), .out_byte(out_byte), .out_is_k(out_is_k),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/rf_formatter_test.sv
module rf_formatter_test;
  localparam int DEPTH   = 16;
  localparam int MAX_REC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = '0;
  logic [3:0]  in_trig = '0;
  logic [7:0]  in_bcid = '0;
  logic [6:0]  in_col = '0;
  logic [8:0]  in_row = '0;
  logic [3:0]  in_tot_top = '0;
  logic [3:0]  in_tot_bot = '0;
  logic        in_reg_type = 1'b0;
  logic [15:0] in_word = '0;
  logic [7:0]  out_byte;
  logic        out_is_k;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit alt_ready = 0;
  int stalls = 0;
  int hold_bad = 0;
  logic [8:0] cap [$];
  logic [8:0] exp_q [$];
  logic [8:0] prev_out;
  bit prev_stall = 0;

  always #5 clk = ~clk;

  rf_formatter #(.DEPTH(DEPTH), .MAX_REC(MAX_REC)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_trig(in_trig), .in_bcid(in_bcid),
    .in_col(in_col), .in_row(in_row), .in_tot_top(in_tot_top),
    .in_tot_bot(in_tot_bot), .in_reg_type(in_reg_type), .in_word(in_word),
    .out_byte(out_byte), .out_is_k(out_is_k), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  always @(posedge clk) if (alt_ready) #1 out_ready <= ~out_ready;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        stalls++;
        if ({out_is_k, out_byte} !== prev_out || !out_valid) hold_bad++;
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_is_k, out_byte};
      if (out_valid && out_ready) cap.push_back({out_is_k, out_byte});
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [23:0] rec_of(input logic [2:0] k, input logic [3:0] tg,
      input logic [7:0] bc, input logic [6:0] c, input logic [8:0] r,
      input logic [3:0] tt, input logic [3:0] tb, input logic rt, input logic [15:0] w);
    case (k)
      3'd0: return (24'hE9 << 16) | (24'(tg) << 8) | 24'(bc);
      3'd1: return (24'(c) << 17) | (24'(r) << 8) | (24'(tt) << 4) | 24'(tb);
      3'd2: return (24'hEA << 16) | (24'(rt) << 15) | 24'(w[14:0]);
      3'd3: return (24'hEC << 16) | 24'(w);
      default: return (24'hEF << 16) | 24'(w);
    endcase
  endfunction

  task automatic e_sof(); exp_q.push_back(9'h1FC); endtask
  task automatic e_eof(); exp_q.push_back(9'h1BC); endtask
  task automatic e_rec(input logic [23:0] r);
    exp_q.push_back({1'b0, r[23:16]});
    exp_q.push_back({1'b0, r[15:8]});
    exp_q.push_back({1'b0, r[7:0]});
  endtask

  // offers one event for one cycle; ok reports acceptance; expected record is queued separately
  task automatic push(input logic [2:0] k, input logic [3:0] tg, input logic [7:0] bc,
      input logic [6:0] c, input logic [8:0] r, input logic [3:0] tt, input logic [3:0] tb,
      input logic rt, input logic [15:0] w, output bit ok, output logic [23:0] rec);
    @(posedge clk); #1;
    in_valid = 1'b1; in_kind = k; in_trig = tg; in_bcid = bc; in_col = c; in_row = r;
    in_tot_top = tt; in_tot_bot = tb; in_reg_type = rt; in_word = w;
    @(negedge clk); ok = in_ready;
    @(posedge clk); #1; in_valid = 1'b0;
    rec = rec_of(k, tg, bc, c, r, tt, tb, rt, w);
  endtask

  task automatic compare(input string req, input string what);
    logic [8:0] f [$];
    bit same;
    int at;
    foreach (cap[i]) if (cap[i] != 9'h13C) f.push_back(cap[i]);
    same = (f.size() == exp_q.size());
    at = -1;
    if (same) foreach (f[i]) if (f[i] != exp_q[i] && at < 0) at = i;
    if (at >= 0) begin
      check(0, req, $sformatf("%s byte %0d", what, at), f[at], exp_q[at]);
    end else begin
      check(same, req, {what, " stream length"}, f.size(), exp_q.size());
    end
  endtask

  task automatic idle_after_last(input string req);
    int last_eof, idles;
    last_eof = -1; idles = 0;
    foreach (cap[i]) if (cap[i] == 9'h1BC) last_eof = i;
    foreach (cap[i]) if (i > last_eof && cap[i] == 9'h13C) idles++;
    check(last_eof >= 0 && idles > 0, req, "idle fill after final end comma", idles, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [23:0] r;
    int acc_n;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid during reset", out_valid, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check(out_valid && out_is_k && out_byte == 8'h3C, "R1", "idle after reset",
          {out_valid, out_is_k, out_byte}, 10'h33C);

    // Test A: preloaded, alternating ready. R2 R3 R4 R5 R6 R8
    cap.delete(); exp_q.delete();
    e_sof();
    push(3'd0, 4'h3, 8'h5A, 0, 0, 0, 0, 0, 0, ok, r); e_rec(r);
    for (int i = 0; i < 5; i++) begin
      push(3'd1, 0, 0, 7'(1 + i * 19), 9'(335 - i * 61), 4'(i + 3), 4'(15 - i), 0, 0, ok, r);
      e_rec(r);
      if (i == 2) begin e_eof(); e_sof(); end
    end
    push(3'd2, 0, 0, 0, 0, 0, 0, 1'b1, 16'h1234, ok, r); e_rec(r);
    push(3'd3, 0, 0, 0, 0, 0, 0, 0, 16'hBEEF, ok, r); e_rec(r);
    e_eof();
    alt_ready = 1;
    repeat (120) @(posedge clk);
    alt_ready = 0; #2 out_ready = 1'b0;
    repeat (3) @(posedge clk);
    compare("R8", "header-hits-address-value burst");
    idle_after_last("R6");
    check(stalls > 10 && hold_bad == 0, "R10", "output changed during stall", hold_bad, 0);

    // Test B: header splits frame, dropped kinds. R7 R12 R4
    cap.delete(); exp_q.delete();
    e_sof();
    push(3'd1, 0, 0, 7'd80, 9'd0, 4'hF, 4'h0, 0, 0, ok, r); e_rec(r);
    push(3'd6, 0, 0, 7'd5, 9'd5, 0, 0, 0, 16'hFFFF, ok, r);
    check(ok, "R12", "unused kind accepted", ok, 1);
    push(3'd1, 0, 0, 7'd1, 9'd1, 4'h1, 4'h2, 0, 0, ok, r); e_rec(r);
    e_eof(); e_sof();
    push(3'd0, 4'hC, 8'hA5, 0, 0, 0, 0, 0, 0, ok, r); e_rec(r);
    push(3'd7, 0, 0, 0, 0, 0, 0, 0, 0, ok, r);
    push(3'd1, 0, 0, 7'd40, 9'd200, 4'h7, 4'h8, 0, 0, ok, r); e_rec(r);
    push(3'd4, 0, 0, 0, 0, 0, 0, 0, 16'h0042, ok, r); e_rec(r);
    push(3'd5, 0, 0, 0, 0, 0, 0, 0, 0, ok, r);
    e_eof();
    out_ready = 1'b1;
    repeat (60) @(posedge clk);
    #1 out_ready = 1'b0;
    repeat (3) @(posedge clk);
    compare("R7", "header split with dropped kinds (R12)");

    // Test C: fill to capacity. R11 R8
    cap.delete(); exp_q.delete();
    acc_n = 0;
    for (int i = 0; i < DEPTH + 1; i++) begin
      push(3'd1, 0, 0, 7'(1 + (i * 5) % 80), 9'(i * 21), 4'(i), 4'(~i), 0, 0, ok, r);
      if (ok) begin
        if (acc_n % MAX_REC == 0) e_sof();
        e_rec(r);
        acc_n++;
        if (acc_n % MAX_REC == 0) e_eof();
      end
      if (i == DEPTH) check(!ok, "R11", "event taken while full", ok, 0);
    end
    check(acc_n == DEPTH, "R11", "events accepted before full", acc_n, DEPTH);
    out_ready = 1'b1;
    repeat (100) @(posedge clk);
    compare("R8", "full queue drained in limited frames");

    // Test D: trickle with ready high. R9 R6
    cap.delete(); exp_q.delete();
    for (int i = 0; i < 3; i++) begin
      push(3'd3, 0, 0, 0, 0, 0, 0, 0, 16'(16'h0100 * (i + 1) + i), ok, r);
      e_sof(); e_rec(r); e_eof();
      repeat (15) @(posedge clk);
    end
    repeat (10) @(posedge clk);
    compare("R9", "single-record frames on empty queue");
    begin
      int gap, min_gap;
      bit open;
      min_gap = 1000; gap = 0; open = 0;
      foreach (cap[i]) begin
        if (cap[i] == 9'h1BC) begin open = 1; gap = 0; end
        else if (cap[i] == 9'h1FC && open) begin
          if (gap < min_gap) min_gap = gap;
          open = 0;
        end else if (cap[i] == 9'h13C && open) gap++;
      end
      check(min_gap >= 1 && min_gap < 1000, "R6", "idle commas between trickled frames", min_gap, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule